// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal. It counts the rising edges of that signal during a gate window whose length is a whole number of milliseconds. The window is timed by a 1 ms tick that the block receives from a crystal-derived timebase. The IF input is asynchronous. It passes through a two-stage synchronizer, and edges are then detected in the system clock domain.

A controller writes a run bit and a 2-bit gate selector. The block samples both only on the cycles where the load strobe is high. A run starts when the sampled run bit goes from 0 to 1. The block then waits a settling interval, counts edges for the gate period, and raises a completion flag. The result stays on the output until the sampled run bit is set back to 0, which clears the count. An inhibit input freezes the measurement while it is held high.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, `count` is 0 and `done` is 0.
- R2: The gate period is 4, 8, 32 or 64 ticks for `gate_sel` values 0, 1, 2 and 3. At the end of a run, `count` equals the IF input frequency times the gate period, within ±1.
- R3: Counting starts only after a settling wait that begins at the start event. The wait is 4 ticks when `gate_sel` is 0 or 1, and 8 ticks when it is 2 or 3. `count` stays 0 during the wait.
- R4: A run starts only when `run` is sampled as 1 at a `load` strobe and the previously sampled value was 0. If `run` is sampled as 1 again while a run is active or complete, nothing changes.
- R5: When `run` is sampled as 0 at a `load` strobe, `count` and `done` both read 0 in the next cycle.
- R6: `done` rises in the cycle after the tick that ends the gate period. From then on, `done` stays high and `count` stays constant until `run` is sampled as 0.
- R7: While `inhibit` is high, the measurement is frozen. Ticks and IF edges are ignored, and `count` and `done` hold their values. A frozen gate therefore ends as many ticks later as it was frozen.
- R8: `count` saturates at all ones instead of wrapping.
- R9: Changes on `run` and `gate_sel` take effect only at a `load` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| load | input | 1 | Strobe; samples `run` and `gate_sel` |
| run | input | 1 | Start (1) or clear (0) |
| gate_sel | input | 2 | Gate period select |
| inhibit | input | 1 | Freezes the measurement |
| if_in | input | 1 | Asynchronous IF signal |
| count | output | CW | Edge count of the last or current gate |
| done | output | 1 | Measurement complete |

## Verification
The bench looks for off-by-one errors in the settling wait and the gate length. It checks `done` on the tick just before the expected end and again just after it, so a design that counted the wait as part of the gate, or mixed up the wait lengths, would raise `done` early or late. A second `load` with `run` high, after a result is ready, must leave the result alone. A design that restarted on the level of the run bit instead of on its 0-to-1 change would clear the result. Inhibit is held high in the middle of a gate: a design that kept counting ticks would finish early with a short count. A narrow-width instance checks that a wrapping counter shows a small value instead of all ones.

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
  parameter int CW = 20,
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          load,
  input  logic          run,
  input  logic [1:0]    gate_sel,
  input  logic          inhibit,
  input  logic          if_in,
  output logic [CW-1:0] count,
  output logic          done
);
  localparam logic [CW-1:0] CMAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GATE, S_DONE} st_t;

  st_t         st;
  logic        run_q;
  logic [1:0]  sel_q;
  logic [TW-1:0] tcnt;
  logic [TW-1:0] wait_last, gate_last;
  logic [2:0]  sync_q;
  logic        rise;

  assign rise = sync_q[1] & ~sync_q[2];
  assign done = (st == S_DONE);
  assign wait_last = sel_q[1] ? TW'(7) : TW'(3);

  always_comb begin
    case (sel_q)
      2'd0:    gate_last = TW'(3);
      2'd1:    gate_last = TW'(7);
      2'd2:    gate_last = TW'(31);
      default: gate_last = TW'(63);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], if_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      run_q <= 1'b0;
      sel_q <= '0;
      tcnt  <= '0;
      count <= '0;
    end else if (load) begin
      run_q <= run;
      if (!run) begin
        st    <= S_IDLE;
        tcnt  <= '0;
        count <= '0;
      end else if (!run_q) begin
        st    <= S_WAIT;
        sel_q <= gate_sel;
        tcnt  <= '0;
        count <= '0;
      end
    end else if (!inhibit) begin
      case (st)
        S_WAIT:
          if (ms_tick) begin
            if (tcnt == wait_last) begin
              st   <= S_GATE;
              tcnt <= '0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        S_GATE: begin
          if (rise && count != CMAX) count <= count + 1'b1;
          if (ms_tick) begin
            if (tcnt == gate_last) st <= S_DONE;
            else                   tcnt <= tcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/if_gate_counter_chk.sv
module if_gate_counter_chk #(
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ms_tick,
  input logic          load,
  input logic          run,
  input logic [1:0]    gate_sel,
  input logic          inhibit,
  input logic          if_in,
  input logic [CW-1:0] count,
  input logic          done
);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !run) |=> (count == '0 && !done));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (done && $stable(count)));

  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done && load && run) |=> (done && $stable(count)));

  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !load) |=> ($stable(count) && $stable(done)));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (&count && !load) |=> (&count));
endmodule

bind if_gate_counter if_gate_counter_chk #(.CW(CW)) u_chk (.*);

// File: tb/test_if_gate_counter.sv
module test_if_gate_counter;
  localparam int TICK = 40;
  localparam int SCW = 6;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, load = 1'b0, run = 1'b0;
  logic inhibit = 1'b0, if_in = 1'b0;
  logic [1:0] gate_sel = 2'd0;
  logic [19:0] count;
  logic done;
  logic [SCW-1:0] s_count;
  logic s_done;
  int half = 50;
  int checks = 0, errors = 0;
  bit finished = 0;

  if_gate_counter i_if_gate_counter (.clk, .rst_n, .ms_tick, .load, .run,
    .gate_sel, .inhibit, .if_in, .count, .done);
  if_gate_counter #(.CW(SCW)) i_if_gate_counter_sat (.clk, .rst_n, .ms_tick,
    .load, .run, .gate_sel, .inhibit, .if_in, .count(s_count), .done(s_done));

  always #5 clk = ~clk;

  initial forever begin
    #(half);
    if_in = ~if_in;
  end

  initial begin
    @(posedge rst_n);
    forever begin
      repeat (TICK - 1) @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  function automatic int gate_ms(input logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 8;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  function automatic int wait_ms(input logic [1:0] s);
    return s[1] ? 8 : 4;
  endfunction

  function automatic real expect_cnt(input logic [1:0] s, input int h);
    return real'(gate_ms(s) * TICK * 10) / real'(2 * h);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!ms_tick);
    end
    @(negedge clk);
  endtask

  task automatic do_load(input logic r, input logic [1:0] s);
    @(negedge clk);
    load = 1'b1; run = r; gate_sel = s;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic measure(input logic [1:0] s, input int h, input string req);
    real e;
    half = h;
    do_load(1'b0, s);
    do_load(1'b1, s);
    wait_ticks(wait_ms(s) + gate_ms(s) - 1);
    check(done == 1'b0, "R6 early", done, 0);
    wait_ticks(1);
    check(done == 1'b1, "R6 done", done, 1);
    e = expect_cnt(s, h);
    check((real'(count) - e) <= 1.0 && (e - real'(count)) <= 1.0, req,
          count, longint'(e));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    check(count == 0, "R1 count", count, 0);
    check(done == 0, "R1 done", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 directed, every gate select
    for (int s = 0; s < 4; s++) measure(2'(s), 25, "R2 directed");

    // R2 random frequencies
    for (int i = 0; i < 6; i++)
      measure(2'($urandom % 4), 20 + ($urandom % 80), "R2 random");

    // R4: reload run=1 while complete
    begin
      logic [19:0] held;
      held = count;
      do_load(1'b1, 2'd0);
      wait_ticks(10);
      check(done == 1'b1 && count == held, "R4 no restart", count, held);
    end

    // R9: run dropped without strobe is ignored
    begin
      logic [19:0] held;
      held = count;
      @(negedge clk);
      run = 1'b0; gate_sel = 2'd3;
      wait_ticks(3);
      check(done == 1'b1 && count == held, "R9 no strobe", count, held);
    end

    // R5: clear on strobe
    do_load(1'b0, 2'd0);
    check(count == 0 && done == 0, "R5 clear", count, 0);

    // R3: settling wait, short gates
    half = 25;
    do_load(1'b1, 2'd1);
    wait_ticks(3);
    check(count == 0, "R3 wait short", count, 0);
    wait_ticks(2);
    check(count != 0, "R3 counting short", count, 1);
    do_load(1'b0, 2'd0);

    // R3: settling wait, long gates
    do_load(1'b1, 2'd2);
    wait_ticks(7);
    check(count == 0, "R3 wait long", count, 0);
    wait_ticks(2);
    check(count != 0, "R3 counting long", count, 1);
    do_load(1'b0, 2'd0);

    // R7: freeze mid-gate for 5 ticks
    begin
      logic [19:0] held;
      real e;
      do_load(1'b1, 2'd1);
      wait_ticks(4 + 3);
      @(negedge clk);
      inhibit = 1'b1;
      @(negedge clk);
      held = count;
      wait_ticks(5);
      check(count == held, "R7 frozen", count, held);
      @(negedge clk);
      inhibit = 1'b0;
      wait_ticks(4);
      check(done == 1'b0, "R7 delayed", done, 0);
      wait_ticks(1);
      check(done == 1'b1, "R7 done", done, 1);
      e = expect_cnt(2'd1, 25);
      check((real'(count) - e) <= 1.0 && (e - real'(count)) <= 1.0, "R7 count",
            count, longint'(e));
    end

    // R8: narrow instance saturates
    half = 10;
    do_load(1'b0, 2'd0);
    do_load(1'b1, 2'd0);
    wait_ticks(8);
    check(s_done == 1'b1, "R8 done", s_done, 1);
    check(&s_count, "R8 saturate", s_count, (1 << SCW) - 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule